// File: doc/BRIEF.md
# Multiprocessor 9-bit UART core

This block is a full-duplex asynchronous serial port. Its behaviour is set by a small set of control inputs:

- a 2-bit frame mode,
- a receive enable,
- an address-filter enable,
- the ninth bit to transmit,
- a rate-doubling select.

It returns the last accepted byte, the ninth bit captured with that byte, and two sticky event flags. Each flag stays set until a clear pulse arrives.

Frames idle high and are sent LSB first. Each frame holds one start bit, eight data bits, an optional ninth bit and one stop bit. In the two 9-bit modes the ninth bit can mark a frame as an address frame. With the filter enabled, data frames (ninth bit 0) are dropped without disturbing the host, so several nodes can share one line. In the 8-bit mode the same filter instead drops frames whose stop bit was sampled low.

The bit clock is a 16x oversampling tick. In the variable-rate modes this tick comes from an external enable input. In the fixed 9-bit mode an internal divider makes it, giving a bit rate of the clock divided by 64, or by 32 when doubling is selected. The receiver synchronises the line, detects a start edge on the tick grid and votes three samples around mid-bit.

Top module: `mpuart_core`

## Requirements
- R1: Mode encoding is 01 = 8-bit frame with external tick, 10 = 9-bit frame with internal fixed rate, 11 = 9-bit frame with external tick. Mode 00 (synchronous shift, not built here) keeps both directions idle: writes are ignored, txd stays 1 and no receive flag is raised.
- R2: A transmitted frame is a start bit 0, then 8 data bits LSB first, then (9-bit modes only) the value of tx_bit9_i latched at the write, then a stop bit 1. The line idles at 1, including after reset.
- R3: tx_flag_o becomes 1 at the start of the stop bit of each transmitted frame.
- R4: rx_flag_o becomes 1 halfway through the stop bit of an accepted received frame, and not before the stop bit.
- R5: Both flags reset to 0, stay set with no further events, and clear only on their clear pulse.
- R6: In the 9-bit modes with addr_filt_i = 1, a frame whose received ninth bit is 0 does not raise rx_flag_o. With a ninth bit of 1, or with the filter off, the frame is accepted.
- R7: In the 8-bit mode with addr_filt_i = 1, a frame whose stop bit samples 0 does not raise rx_flag_o. With the filter off it is accepted.
- R8: rx_data_o and rx_bit9_o change only when a frame is accepted. rx_bit9_o then holds the received ninth bit (9-bit modes) or the sampled stop bit (8-bit mode). Both reset to 0.
- R9: With rx_en_i = 0 no frame is received and rx_flag_o, rx_data_o and rx_bit9_o keep their values.
- R10: In mode 10 the bit time is 64 clocks with rate_dbl_i = 0 and 32 clocks with rate_dbl_i = 1. Internal ticks never fall on two consecutive clocks.
- R11: In modes 01 and 11 each bit lasts 16 pulses of ext_tick_i.
- R12: A start edge whose line is back at 1 at mid-bit is discarded. The receiver returns to idle and then accepts the next valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Frame mode select |
| addr_filt_i | input | 1 | Multiprocessor address filter enable |
| rx_en_i | input | 1 | Receive enable |
| tx_bit9_i | input | 1 | Ninth bit for transmission, latched at write |
| rate_dbl_i | input | 1 | Halves the fixed-mode divider |
| ext_tick_i | input | 1 | 16x oversampling enable for modes 01 and 11 |
| wr_i | input | 1 | Write strobe starting a transmission when idle |
| wr_data_i | input | 8 | Byte to transmit |
| clr_tx_flag_i | input | 1 | Clears the transmit flag |
| clr_rx_flag_i | input | 1 | Clears the receive flag |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| tx_flag_o | output | 1 | Sticky transmit-done flag |
| rx_flag_o | output | 1 | Sticky receive-done flag |
| rx_data_o | output | 8 | Last accepted byte |
| rx_bit9_o | output | 1 | Ninth or stop bit of the last accepted frame |

## Verification
The assertions check the following on every cycle:

- the flags are sticky without a clear;
- the received byte never changes unless the receive flag is set;
- frames the filter drops never raise the receive flag, in both the ninth-bit and the stop-bit forms;
- a disabled receiver or a mode-00 transmitter stays idle;
- bit counters advance only on ticks;
- fixed-rate ticks are spaced.

Only the bench scenarios can show the rest:

- the serial bit order on the line;
- where within the stop bit each flag rises;
- the actual bit period in each mode and rate;
- recovery from a false start;
- that suppressed frames leave the captured byte and ninth bit untouched at the ports.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef enum logic [1:0] {
    MD_SHIFT  = 2'b00,
    MD_UART8  = 2'b01,
    MD_UART9F = 2'b10,
    MD_UART9V = 2'b11
  } mpu_mode_e;

  typedef enum logic [2:0] {
    SER_IDLE,
    SER_START,
    SER_DATA,
    SER_NINTH,
    SER_STOP
  } ser_state_e;

endpackage

// File: rtl/mpu_tick_gen.sv
module mpu_tick_gen #(
  parameter int FIX_DIV = 64,
  parameter int OVS     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fixed_sel_i,
  input  logic dbl_i,
  input  logic ext_tick_i,
  output logic tick_o
);

  localparam int SLOW = FIX_DIV / OVS;
  localparam int FAST = SLOW / 2;
  localparam int DW   = (SLOW > 1) ? $clog2(SLOW) : 1;

  logic [DW-1:0] div_q, div_d;
  logic [DW-1:0] lim;
  logic          wrap;

  always_comb begin
    lim   = dbl_i ? DW'(FAST - 1) : DW'(SLOW - 1);
    wrap  = (div_q >= lim);
    div_d = (!fixed_sel_i || wrap) ? '0 : div_q + 1'b1;
    tick_o = fixed_sel_i ? wrap : ext_tick_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  AST_FIX_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_sel_i && tick_o) |=> !(fixed_sel_i && tick_o)); // R10

endmodule

// File: rtl/mpu_tx.sv
module mpu_tx
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit9_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              stop_begin_o
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);

  ser_state_e        st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              b9_q, b9_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;

  always_comb begin
    st_d = st_q; sh_d = sh_q; b9_d = b9_q; tcnt_d = tcnt_q; bidx_d = bidx_q;
    stop_begin_o = 1'b0;
    if (!en_i) begin
      st_d = SER_IDLE;
    end else if (st_q == SER_IDLE) begin
      if (load_i) begin
        st_d   = SER_START;
        sh_d   = data_i;
        b9_d   = bit9_i;
        tcnt_d = '0;
      end
    end else if (tick_i) begin
      if (tcnt_q != CNT_W'(OVS - 1)) begin
        tcnt_d = tcnt_q + 1'b1;
      end else begin
        tcnt_d = '0;
        case (st_q)
          SER_START: begin
            st_d   = SER_DATA;
            bidx_d = '0;
          end
          SER_DATA: begin
            sh_d = sh_q >> 1;
            if (bidx_q == IDX_W'(DATA_W - 1)) begin
              if (nine_i) begin
                st_d = SER_NINTH;
              end else begin
                st_d = SER_STOP;
                stop_begin_o = 1'b1;
              end
            end else begin
              bidx_d = bidx_q + 1'b1;
            end
          end
          SER_NINTH: begin
            st_d = SER_STOP;
            stop_begin_o = 1'b1;
          end
          default: st_d = SER_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SER_IDLE;
      sh_q   <= '0;
      b9_q   <= 1'b0;
      tcnt_q <= '0;
      bidx_q <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      b9_q   <= b9_d;
      tcnt_q <= tcnt_d;
      bidx_q <= bidx_d;
    end
  end

  always_comb begin
    case (st_q)
      SER_START: txd_o = 1'b0;
      SER_DATA:  txd_o = sh_q[0];
      SER_NINTH: txd_o = b9_q;
      default:   txd_o = 1'b1;
    endcase
    busy_o = (st_q != SER_IDLE);
  end

  AST_TX_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SER_IDLE && en_i && !tick_i) |=> $stable(tcnt_q)); // R11

endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              stop_o
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_A = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] MID_B = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] MID_C = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OVS - 1);

  ser_state_e        st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              b9_q, b9_d;
  logic              prev_q, prev_d;
  logic [1:0]        vote_q, vote_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic              bit_v;

  always_comb begin
    st_d = st_q; sh_d = sh_q; b9_d = b9_q; prev_d = prev_q;
    vote_d = vote_q; tcnt_d = tcnt_q; bidx_d = bidx_q;
    done_o = 1'b0;
    bit_v  = (vote_q[0] & vote_q[1]) | (vote_q[0] & rxd_i) | (vote_q[1] & rxd_i);
    if (tick_i) prev_d = rxd_i;
    if (!en_i) begin
      st_d = SER_IDLE;
    end else if (tick_i) begin
      if (st_q == SER_IDLE) begin
        if (prev_q && !rxd_i) begin
          st_d   = SER_START;
          tcnt_d = '0;
        end
      end else begin
        tcnt_d = (tcnt_q == LAST) ? '0 : tcnt_q + 1'b1;
        if (tcnt_q == MID_A) vote_d[0] = rxd_i;
        if (tcnt_q == MID_B) vote_d[1] = rxd_i;
        if (tcnt_q == MID_C) begin
          case (st_q)
            SER_START: if (bit_v) st_d = SER_IDLE;
            SER_DATA:  sh_d = {bit_v, sh_q[DATA_W-1:1]};
            SER_NINTH: b9_d = bit_v;
            SER_STOP: begin
              done_o = 1'b1;
              st_d   = SER_IDLE;
            end
            default: st_d = SER_IDLE;
          endcase
        end
        if (tcnt_q == LAST) begin
          case (st_q)
            SER_START: begin
              st_d   = SER_DATA;
              bidx_d = '0;
            end
            SER_DATA: begin
              if (bidx_q == IDX_W'(DATA_W - 1)) st_d = nine_i ? SER_NINTH : SER_STOP;
              else                               bidx_d = bidx_q + 1'b1;
            end
            SER_NINTH: st_d = SER_STOP;
            default:   st_d = st_q;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SER_IDLE;
      sh_q   <= '0;
      b9_q   <= 1'b0;
      prev_q <= 1'b1;
      vote_q <= 2'b11;
      tcnt_q <= '0;
      bidx_q <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      b9_q   <= b9_d;
      prev_q <= prev_d;
      vote_q <= vote_d;
      tcnt_q <= tcnt_d;
      bidx_q <= bidx_d;
    end
  end

  assign data_o = sh_q;
  assign bit9_o = b9_q;
  assign stop_o = bit_v;

  AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == SER_IDLE && !done_o)); // R9

endmodule

// File: rtl/mpuart_core.sv
module mpuart_core
  import mpu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int FIX_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              addr_filt_i,
  input  logic              rx_en_i,
  input  logic              tx_bit9_i,
  input  logic              rate_dbl_i,
  input  logic              ext_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_tx_flag_i,
  input  logic              clr_rx_flag_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              tx_flag_o,
  output logic              rx_flag_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o
);

  mpu_mode_e         mode_e;
  logic              active, nine, tick;
  logic              rxd_m_q, rxd_s_q;
  logic              tx_busy, tx_stop_begin;
  logic              rx_done, rx_b9, rx_stop, accept;
  logic [DATA_W-1:0] rx_dout;

  logic              txf_q, txf_d, rxf_q, rxf_d, rb9_q, rb9_d;
  logic [DATA_W-1:0] rbyte_q, rbyte_d;

  assign mode_e = mpu_mode_e'(mode_i);
  assign active = (mode_e != MD_SHIFT);
  assign nine   = mode_i[1];

  mpu_tick_gen #(.FIX_DIV(FIX_DIV), .OVS(OVS)) i_tick (
    .clk(clk), .rst_n(rst_n),
    .fixed_sel_i(mode_e == MD_UART9F), .dbl_i(rate_dbl_i),
    .ext_tick_i(ext_tick_i), .tick_o(tick)
  );

  mpu_tx #(.DATA_W(DATA_W), .OVS(OVS)) i_tx (
    .clk(clk), .rst_n(rst_n), .en_i(active), .nine_i(nine), .tick_i(tick),
    .load_i(wr_i), .data_i(wr_data_i), .bit9_i(tx_bit9_i),
    .txd_o(txd_o), .busy_o(tx_busy), .stop_begin_o(tx_stop_begin)
  );

  mpu_rx #(.DATA_W(DATA_W), .OVS(OVS)) i_rx (
    .clk(clk), .rst_n(rst_n), .en_i(active && rx_en_i), .nine_i(nine),
    .tick_i(tick), .rxd_i(rxd_s_q), .done_o(rx_done), .data_o(rx_dout),
    .bit9_o(rx_b9), .stop_o(rx_stop)
  );

  always_comb begin
    if (nine) accept = rx_done && !(addr_filt_i && !rx_b9);
    else      accept = rx_done && !(addr_filt_i && !rx_stop);
    txf_d   = tx_stop_begin ? 1'b1 : (clr_tx_flag_i ? 1'b0 : txf_q);
    rxf_d   = accept        ? 1'b1 : (clr_rx_flag_i ? 1'b0 : rxf_q);
    rbyte_d = accept ? rx_dout : rbyte_q;
    rb9_d   = accept ? (nine ? rx_b9 : rx_stop) : rb9_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m_q <= 1'b1;
      rxd_s_q <= 1'b1;
      txf_q   <= 1'b0;
      rxf_q   <= 1'b0;
      rbyte_q <= '0;
      rb9_q   <= 1'b0;
    end else begin
      rxd_m_q <= rxd_i;
      rxd_s_q <= rxd_m_q;
      txf_q   <= txf_d;
      rxf_q   <= rxf_d;
      rbyte_q <= rbyte_d;
      rb9_q   <= rb9_d;
    end
  end

  assign tx_flag_o = txf_q;
  assign rx_flag_o = rxf_q;
  assign rx_data_o = rbyte_q;
  assign rx_bit9_o = rb9_q;

  AST_MODE0_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MD_SHIFT) |=> !tx_busy); // R1
  AST_TXF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flag_o && !clr_tx_flag_i) |=> tx_flag_o); // R5
  AST_RXF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag_o && !clr_rx_flag_i) |=> rx_flag_o); // R5
  AST_FILT_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && nine && addr_filt_i && !rx_b9 && !rx_flag_o) |=> !rx_flag_o); // R6
  AST_FILT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !nine && addr_filt_i && !rx_stop && !rx_flag_o) |=> !rx_flag_o); // R7
  AST_RXDATA_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data_o) |-> rx_flag_o); // R8

endmodule

// File: tb/test_mpuart_core.sv
module test_mpuart_core;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int PER_EXT    = 16 * TICK_DIV;

  logic       clk, rst_n;
  logic [1:0] mode;
  logic       filt, rx_en, tx_b9, dbl, ext_tick, wr, clr_tx, clr_rx;
  logic [7:0] wr_data;
  logic       rxd_drv, loop_en, rxd, txd, tx_flag, rx_flag, rx_bit9;
  logic [7:0] rx_data;

  int   n_vec, n_bad;
  logic [7:0] m_byte;
  logic       m_bit9;

  assign rxd = loop_en ? txd : rxd_drv;

  mpuart_core i_mpuart_core (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .addr_filt_i(filt), .rx_en_i(rx_en),
    .tx_bit9_i(tx_b9), .rate_dbl_i(dbl), .ext_tick_i(ext_tick), .wr_i(wr),
    .wr_data_i(wr_data), .clr_tx_flag_i(clr_tx), .clr_rx_flag_i(clr_rx),
    .rxd_i(rxd), .txd_o(txd), .tx_flag_o(tx_flag), .rx_flag_o(rx_flag),
    .rx_data_o(rx_data), .rx_bit9_o(rx_bit9)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    ext_tick = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      ext_tick = 1'b1;
      @(negedge clk);
      ext_tick = 1'b0;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr;
    clr_rx = 1'b1; clr_tx = 1'b1;
    @(negedge clk);
    clr_rx = 1'b0; clr_tx = 1'b0;
  endtask

  // Drives one frame on rxd and checks flag placement and captured values.
  task automatic rx_frame(input string tag, input logic live, input logic [7:0] data,
                          input logic b9, input logic stopv, input int per);
    logic nine, acc;
    nine = mode[1];
    if (nine) acc = live && !(filt && !b9);
    else      acc = live && !(filt && !stopv);
    pulse_clr;
    rxd_drv = 1'b0;
    wait_clk(per);
    for (int i = 0; i < 8; i++) begin
      rxd_drv = data[i];
      wait_clk(per);
    end
    if (nine) begin
      rxd_drv = b9;
      wait_clk(per);
    end
    rxd_drv = stopv;
    wait_clk(per / 4);
    chk({tag, " R4 early flag"}, rx_flag, 0);
    wait_clk(per * 7 / 8 - per / 4);
    chk({tag, " flag"}, rx_flag, acc);
    wait_clk(per / 8);
    rxd_drv = 1'b1;
    wait_clk(per * 2);
    if (acc) begin
      m_byte = data;
      m_bit9 = nine ? b9 : stopv;
    end
    chk({tag, " R8 byte"}, rx_data, m_byte);
    chk({tag, " R8 bit9"}, rx_bit9, m_bit9);
  endtask

  // Transmits in loopback, checks the line bit by bit and both flags.
  task automatic tx_frame(input string tag, input logic [7:0] data, input logic b9, input int per);
    logic nine;
    nine = mode[1];
    pulse_clr;
    tx_b9 = b9;
    wr_data = data;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    tx_b9 = ~b9;
    wait_clk(per / 2);
    chk({tag, " R2 start"}, txd, 0);
    for (int i = 0; i < 8; i++) begin
      wait_clk(per);
      chk({tag, " R2 data"}, txd, data[i]);
    end
    if (nine) begin
      wait_clk(per);
      chk({tag, " R2 ninth"}, txd, b9);
    end
    chk({tag, " R3 flag before stop"}, tx_flag, 0);
    wait_clk(per);
    chk({tag, " R2 stop"}, txd, 1);
    chk({tag, " R3 flag in stop"}, tx_flag, 1);
    wait_clk(per);
    chk({tag, " R4 loop flag"}, rx_flag, 1);
    chk({tag, " R8 loop byte"}, rx_data, data);
    chk({tag, " R8 loop bit9"}, rx_bit9, nine ? b9 : 1'b1);
    m_byte = data;
    m_bit9 = nine ? b9 : 1'b1;
    wait_clk(per);
  endtask

  initial begin
    n_vec = 0; n_bad = 0;
    m_byte = 8'h00; m_bit9 = 1'b0;
    rst_n = 1'b0; mode = 2'b00; filt = 1'b0; rx_en = 1'b0; tx_b9 = 1'b0;
    dbl = 1'b0; wr = 1'b0; wr_data = 8'h00; clr_tx = 1'b0; clr_rx = 1'b0;
    rxd_drv = 1'b1; loop_en = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R2 reset txd", txd, 1);
    chk("R5 reset tx_flag", tx_flag, 0);
    chk("R5 reset rx_flag", rx_flag, 0);
    chk("R8 reset data", rx_data, 0);
    chk("R8 reset bit9", rx_bit9, 0);

    // Mode 01, external tick: byte sweep, filter off (R11)
    mode = 2'b01; rx_en = 1'b1;
    for (int v = 0; v < 256; v += 17) rx_frame("R11 mode01", 1'b1, 8'(v), 1'b0, 1'b1, PER_EXT);

    // R5: flag sticks without clear, clear pulse drops it
    wait_clk(3 * PER_EXT);
    chk("R5 sticky rx", rx_flag, 1);
    pulse_clr;
    chk("R5 cleared rx", rx_flag, 0);

    // R7: stop-bit filter in 8-bit mode
    for (int f = 0; f < 2; f++) begin
      filt = f[0];
      rx_frame("R7 stop0", 1'b1, 8'hC3, 1'b0, 1'b0, PER_EXT);
      rx_frame("R7 stop1", 1'b1, 8'h3C + 8'(f), 1'b0, 1'b1, PER_EXT);
    end

    // R6: ninth-bit filter, mode 11 external tick and mode 10 both rates (R10)
    for (int m = 0; m < 3; m++) begin
      int per;
      mode = (m == 0) ? 2'b11 : 2'b10;
      dbl  = (m == 2);
      per  = (m == 2) ? 32 : 64;
      for (int f = 0; f < 2; f++) begin
        for (int b = 0; b < 2; b++) begin
          filt = f[0];
          rx_frame(m == 0 ? "R6 mode11" : "R6 R10 mode10", 1'b1,
                   8'hA5 ^ 8'(16 * m + 4 * f + b), b[0], 1'b1, per);
        end
      end
    end
    filt = 1'b0; dbl = 1'b0;

    // R12: false start then a valid frame
    mode = 2'b01;
    pulse_clr;
    rxd_drv = 1'b0;
    wait_clk(PER_EXT / 4);
    rxd_drv = 1'b1;
    wait_clk(2 * PER_EXT);
    chk("R12 no flag on glitch", rx_flag, 0);
    chk("R12 data kept", rx_data, m_byte);
    rx_frame("R12 after glitch", 1'b1, 8'h81, 1'b0, 1'b1, PER_EXT);

    // R9: receiver disabled
    rx_en = 1'b0;
    rx_frame("R9 rx off", 1'b0, 8'h18, 1'b0, 1'b1, PER_EXT);
    rx_en = 1'b1;

    // R1: mode 00 keeps both directions idle
    mode = 2'b00;
    rx_frame("R1 mode00 rx", 1'b0, 8'h77, 1'b0, 1'b1, PER_EXT);
    wr_data = 8'h00; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wait_clk(PER_EXT / 2);
      chk("R1 mode00 txd", txd, 1);
    end
    chk("R1 mode00 tx_flag", tx_flag, 0);

    // R2 R3: loopback transmissions
    loop_en = 1'b1;
    mode = 2'b01;
    tx_frame("mode01", 8'h00, 1'b0, PER_EXT);
    tx_frame("mode01", 8'hFF, 1'b0, PER_EXT);
    tx_frame("mode01", 8'h96, 1'b1, PER_EXT);
    mode = 2'b11;
    tx_frame("mode11", 8'h69, 1'b1, PER_EXT);
    tx_frame("mode11", 8'h5A, 1'b0, PER_EXT);
    mode = 2'b10; dbl = 1'b0;
    tx_frame("R10 mode10 slow", 8'h2D, 1'b1, 64);
    dbl = 1'b1;
    tx_frame("R10 mode10 fast", 8'hD2, 1'b0, 32);
    tx_frame("R10 mode10 fast", 8'h01, 1'b1, 32);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait_clk(190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule